// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

This block gives several processors on one shared bus a set of hardware mutual-exclusion locks. Each lock occupies one 32-bit word. A processor tries to take a lock by reading its word. If the read returns zero, the lock was free, and the same access has now marked it taken, so that processor owns it. If the read returns one, another owner already holds the lock, and nothing changes. The owner releases the lock by writing zero to the word.

A read-only status word reports the size of the bank as an encoded count field. The number of locks is a compile-time parameter and may be 32, 64, 128 or 256. The bus is a simple single-cycle register port. Read data is registered and appears in the cycle after the read strobe.

Top module: `hw_lock_bank`

## Requirements
- R1: A read of offset 0x000 returns the status word. Bits 30:28 hold the code n, where NUM_LOCKS = 2^(4+n): 0x10000000 for 32 locks, 0x20000000 for 64, 0x30000000 for 128 and 0x40000000 for 256. All other bits are zero.
- R2: A read of a free lock at offset 0x100 + 4*i returns 0x00000000 and marks that lock taken in the same access. Read data appears in the clock cycle after the cycle in which rd_en is sampled high.
- R3: A read of a taken lock returns 0x00000001 and leaves the lock taken.
- R4: Two reads of the same free lock in consecutive cycles return exactly one zero: the first read returns 0 and the second returns 1.
- R5: A write of 0 to a lock word releases that lock. A write of any nonzero value to a lock word is ignored.
- R6: Writes to the status word have no effect on the status value or on any lock.
- R7: Reset, which is synchronous and active high, frees every lock and clears rdata to 0.
- R8: A read of an unmapped or unaligned offset returns 0 and takes no lock. A write to such an offset releases no lock. Unmapped offsets are 0x004 to 0x0FC, 0x100 + 4*NUM_LOCKS and above, and any offset with bits 1:0 not zero.
- R9: In the cycle after a cycle with rd_en low, rdata is 0.
- R10: When rd_en and wr_en are high in the same cycle, the access is treated as a read only, and the write is dropped.
- R11: Taking or releasing one lock never changes the state of any other lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe; a read of a lock word acts as test-and-set |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one cycle after rd_en |

## Verification
The test-and-set is tried in four patterns. An isolated read of a free lock checks the zero return and the set. A repeated read checks that the lock reads as taken. Reads of the same word in consecutive cycles check that the state is updated on the same edge that returns the zero. A sweep over every lock and its first word past the end checks indexing and the upper bound of the range. Writes of zero and of nonzero data tell a release apart from an ignored write. Out-of-range and unaligned writes are made while a lock is held, so that a decode which wraps the index shows up as an unexpected release. A cycle with both strobes high shows whether the write is dropped.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned STATUS_OFS  = 'h000;
  localparam int unsigned LOCK_BASE   = 'h100;
  localparam int unsigned CODE_LSB    = 28;
  localparam int unsigned CODE_W      = 3;

  // count code: NUM_LOCKS = 2^(4+code)
  function automatic logic [CODE_W-1:0] count_code(input int unsigned n);
    case (n)
      32:      count_code = 3'd1;
      64:      count_code = 3'd2;
      128:     count_code = 3'd3;
      256:     count_code = 3'd4;
      default: count_code = 3'd0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input int unsigned n);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CODE_LSB +: CODE_W] = count_code(n);
    status_word = w;
  endfunction
endpackage

// File: rtl/spl_decode.sv
module spl_decode
  import spl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_status,
  output logic              hit_lock,
  output logic [IDX_W-1:0]  lock_idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(LOCK_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(4 * NUM_LOCKS);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off        = addr - BASE_A;
    hit_status = (addr == ADDR_W'(STATUS_OFS));
    hit_lock   = (addr >= BASE_A) && (off < SPAN_A) && (off[1:0] == 2'b00);
    lock_idx   = off[IDX_W+1:2];
  end
endmodule

// File: rtl/spl_lock_array.sv
module spl_lock_array #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acquire,
  input  logic             release_i,
  input  logic [IDX_W-1:0] idx,
  output logic             taken_at_idx
);
  logic [NUM_LOCKS-1:0] taken_q;

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    logic sel;
    assign sel = (idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst)                   taken_q[i] <= 1'b0;
      else if (acquire && sel)   taken_q[i] <= 1'b1;
      else if (release_i && sel) taken_q[i] <= 1'b0;
    end
  end

  assign taken_at_idx = taken_q[idx];
endmodule

// File: rtl/spl_rd_path.sv
module spl_rd_path
  import spl_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              hit_status,
  input  logic              hit_lock,
  input  logic              taken,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [WORD_W-1:0] STATUS_VAL = status_word(NUM_LOCKS);

  logic [WORD_W-1:0] next_d;

  always_comb begin
    next_d = '0;
    if (rd) begin
      if (hit_status)    next_d = STATUS_VAL;
      else if (hit_lock) next_d = {{(WORD_W-1){1'b0}}, taken};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= next_d;
  end
endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank
  import spl_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int unsigned IDX_W = $clog2(NUM_LOCKS);

  if (count_code(NUM_LOCKS) == 3'd0) begin : g_bad_count
    $error("NUM_LOCKS must be 32, 64, 128 or 256");
  end

  logic             hit_status, hit_lock;
  logic [IDX_W-1:0] lock_idx;
  logic             taken;
  logic             do_acquire, do_release;

  spl_decode #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_decode (
    .addr(addr), .hit_status(hit_status), .hit_lock(hit_lock), .lock_idx(lock_idx)
  );

  // a read wins over a simultaneous write
  assign do_acquire = rd_en && hit_lock;
  assign do_release = wr_en && !rd_en && hit_lock && (wdata == '0);

  spl_lock_array #(.NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_locks (
    .clk(clk), .rst(rst), .acquire(do_acquire), .release_i(do_release),
    .idx(lock_idx), .taken_at_idx(taken)
  );

  spl_rd_path #(.NUM_LOCKS(NUM_LOCKS)) u_rd (
    .clk(clk), .rst(rst), .rd(rd_en), .hit_status(hit_status),
    .hit_lock(hit_lock), .taken(taken), .rdata(rdata)
  );
endmodule

// File: rtl/spl_checker.sv
module spl_checker #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata
);
  localparam logic [31:0] EXP_STATUS = 32'($clog2(NUM_LOCKS) - 4) << 28;

  logic in_lock_range;
  assign in_lock_range = (32'(addr) >= 32'h100) &&
                         (32'(addr) < 32'h100 + 4 * NUM_LOCKS) &&
                         (addr[1:0] == 2'b00);

  a_r1_status_word: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == '0) |=> (rdata == EXP_STATUS));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

  a_r3_lock_read_binary: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_lock_range) |=> (rdata[31:1] == '0));

  a_r4_one_zero_pair: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_lock_range && $past(rd_en) && !$past(rst) && $past(addr) == addr)
      |=> (rdata == 32'd1));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_lock_range && addr != '0) |=> (rdata == '0));

  logic unused_ok;
  assign unused_ok = wr_en ^ (^wdata);
endmodule

bind hw_lock_bank spl_checker #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .rdata(rdata)
);

// File: tb/test_hw_lock_bank.sv
`timescale 1ns/1ps
module test_hw_lock_bank;
  localparam int unsigned N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hw_lock_bank #(.NUM_LOCKS(N), .ADDR_W(12)) i_hw_lock_bank (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [11:0] la(input int i);
    return 12'(32'h100 + 4 * i);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b0; addr = a;
    @(negedge clk); d = rdata; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    @(negedge clk);
    chk("R7 rdata after reset", rdata, 32'h0);
    rd(la(3), d); chk("R2 first take lock3", d, 32'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R7 rdata cleared", rdata, 32'h0);
    rd(la(3), d); chk("R7 lock3 freed by reset", d, 32'h0);
    wr(la(3), 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    rd(12'h000, d); chk("R1 status word", d, 32'h1000_0000);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, d); chk("R6 status after write", d, 32'h1000_0000);
    wr(12'h000, 32'h0);
    rd(la(0), d); chk("R6 lock0 untouched by status write", d, 32'h0);
    wr(la(0), 32'h0);
  endtask

  task automatic t_take_release();
    logic [31:0] d;
    rd(la(7), d); chk("R2 take lock7", d, 32'h0);
    rd(la(7), d); chk("R3 lock7 taken", d, 32'h1);
    rd(la(7), d); chk("R3 lock7 still taken", d, 32'h1);
    wr(la(7), 32'h0000_0001);
    rd(la(7), d); chk("R5 nonzero write ignored", d, 32'h1);
    wr(la(7), 32'h0);
    rd(la(7), d); chk("R5 zero write released", d, 32'h0);
    wr(la(7), 32'h0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] d1, d2;
    @(negedge clk); rd_en = 1'b1; addr = la(9);
    @(negedge clk); d1 = rdata;
    @(negedge clk); d2 = rdata; rd_en = 1'b0;
    chk("R4 first of pair", d1, 32'h0);
    chk("R4 second of pair", d2, 32'h1);
    @(negedge clk);
    chk("R9 idle read data", rdata, 32'h0);
    wr(la(9), 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(12'h004, d); chk("R8 offset 0x004", d, 32'h0);
    rd(12'h0FC, d); chk("R8 offset 0x0FC", d, 32'h0);
    rd(la(N), d);   chk("R8 first past end", d, 32'h0);
    rd(12'h102, d); chk("R8 unaligned", d, 32'h0);
    rd(la(0), d);   chk("R8 lock0 not taken by unaligned", d, 32'h0);
    wr(la(N), 32'h0);
    wr(12'h101, 32'h0);
    rd(la(0), d);   chk("R8 lock0 not released by unmapped write", d, 32'h1);
    wr(la(0), 32'h0);
  endtask

  task automatic t_simultaneous();
    logic [31:0] d;
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; addr = la(5); wdata = 32'h0;
    @(negedge clk); d = rdata; rd_en = 1'b0; wr_en = 1'b0;
    chk("R10 read wins, free", d, 32'h0);
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; addr = la(5); wdata = 32'h0;
    @(negedge clk); d = rdata; rd_en = 1'b0; wr_en = 1'b0;
    chk("R10 read wins, taken", d, 32'h1);
    rd(la(5), d); chk("R10 write dropped", d, 32'h1);
    wr(la(5), 32'h0);
  endtask

  task automatic t_sweep();
    logic [31:0] d;
    for (int i = 0; i < N; i += 2) begin
      rd(la(i), d); chk("R2 sweep take even", d, 32'h0);
    end
    for (int i = 0; i < N; i++) begin
      rd(la(i), d);
      chk("R11 sweep state", d, (i % 2 == 0) ? 32'h1 : 32'h0);
    end
    wr(la(N-1), 32'h0);
    rd(la(N-2), d); chk("R11 neighbour kept", d, 32'h1);
    for (int i = 0; i < N; i++) wr(la(i), 32'h0);
    for (int i = 0; i < N; i++) begin
      rd(la(i), d); chk("R5 sweep released", d, 32'h0);
    end
    for (int i = 0; i < N; i++) wr(la(i), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset_state();
    t_status();
    t_take_release();
    t_back_to_back();
    t_unmapped();
    t_simultaneous();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule